// File: doc/BRIEF.md
# Flash Command Read-Mode Controller

This block sits behind the bus pins of an asynchronous parallel NOR flash and holds the part's command interface and read-path steering. It watches the chip-enable, output-enable and write-enable strobes through two-flop synchronizers on a system clock. It decodes command bytes written on the data bus and remembers which read mode is current: array, identifier or status.

The read data bus is driven from one of four sources. These are the array word supplied by an external memory port, a fixed manufacturer or device code, the lock bit of an addressed block, or a status byte. The status byte is frozen when a read access begins. A separate write state machine supplies a busy level, a suspended level and one-cycle pulses that raise sticky error flags. The block never clears those flags on its own.

Top module: `nor_cmd_readmux`

## Requirements
- R1: When reset is released the block is in array mode, all sticky error flags are 0, and dq_out equals arr_data in word mode.
- R2: A command byte on dq_in is taken when the synchronized we_n rises while the synchronized ce_n is low; a we_n rise with ce_n high changes nothing.
- R3: In identifier mode (command 90H), word address 0 reads 00B0H and address 1 reads 00E9H. An address whose low BLK_W bits equal 2 reads the lock bit of block addr[ADDR_W-1:BLK_W] on bit 0, with 1 meaning locked. Every other address and every other bit reads 0.
- R4: With byte_mode high, dq_out[15:8] reads 0. Identifier reads ignore addr_lsb. Array reads return arr_data[15:8] when addr_lsb is 1 and arr_data[7:0] when it is 0.
- R5: In status mode (command 70H), dq_out is {8'h00, latched status}. The status byte is built as follows: bit 7 is ready (the inverse of wsm_busy), bit 6 is wsm_susp, and bits 5, 4, 3 and 1 hold the sticky flags raised by err_set[3], err_set[2], err_set[1] and err_set[0]. Bits 2 and 0 are 0.
- R6: Sticky flags accumulate over several err_set pulses. Command 50H clears all of them and leaves the read mode unchanged.
- R7: The status byte is captured in the cycle where the synchronized pair {ce_n, oe_n} leaves the both-high state. It holds until both strobes have been high again and one of them falls.
- R8: Command FFH is refused while wsm_busy is high and wsm_susp is low. It is accepted when the machine is idle or suspended.
- R9: Each read mode persists until another recognised command is written; any code other than FFH, 90H, 70H or 50H changes nothing.
- R10: When an err_set pulse and the clear command act in the same clock cycle, the pulsed flags end up set and the other flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | ADDR_W | Word address |
| addr_lsb | input | 1 | Byte select line, used only in byte mode |
| byte_mode | input | 1 | 1 selects the 8-bit bus width |
| dq_in | input | 8 | Command byte, stable around the we_n rise |
| wsm_busy | input | 1 | Write state machine is running an operation |
| wsm_susp | input | 1 | Write state machine is suspended |
| err_set | input | 4 | One-cycle pulses raising the sticky error flags |
| lock_bits | input | 2**(ADDR_W-BLK_W) | Lock state per block, 1 = locked |
| arr_data | input | 16 | Word read from the external array port |
| dq_out | output | 16 | Read data bus |

## Verification
The clear command and an error-flag pulse from the write machine can land in the same clock cycle. The bench aligns them by releasing we_n on a known falling clock edge and counting the two synchronizer stages plus the edge detector. It then raises err_set exactly for the third rising edge. The outcome is read back as a status byte after a fresh output-enable toggle. Only the pulsed flag may survive, and the flags set before the collision must be gone. A second overlap, a status capture while the busy level changes under an open access, is judged by checking that the byte on dq_out does not change until both enables have gone high again.

// File: rtl/nor_rd_pkg.sv
// Shared types and constants for the flash command read-mode controller.
package nor_rd_pkg;

    localparam int DQ_W = 16;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_STATUS = 2'd2
    } rd_mode_t;

    localparam logic [7:0] CMD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_STATUS = 8'h70;
    localparam logic [7:0] CMD_CLEAR  = 8'h50;

    localparam logic [7:0] ID_MFR = 8'hB0;
    localparam logic [7:0] ID_DEV = 8'hE9;

    // Offset inside a block at which its lock bit is reported.
    localparam int LOCK_OFS = 2;

endpackage

// File: rtl/nor_sync.sv
// nor_sync: two-flop synchronizer bank for asynchronous strobes.
// Assumes each bit is an independent level; RST_VAL is the idle level.
module nor_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;
    logic [W-1:0] stab;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Two-stage capture of one asynchronous bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta[i] <= RST_VAL[i];
                stab[i] <= RST_VAL[i];
            end else begin
                meta[i] <= d_async[i];
                stab[i] <= meta[i];
            end
        end
    end

    assign q = stab;
endmodule

// File: rtl/nor_cmd_decode.sv
// nor_cmd_decode: detects write and read-start edges on the synchronized
// strobes and holds the current read mode.
// Assumes cmd_byte is stable while the synchronized we_n rise is seen.
module nor_cmd_decode
    import nor_rd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ce_s,
    input  logic     oe_s,
    input  logic     we_s,
    input  logic [7:0] cmd_byte,
    input  logic     wsm_busy,
    input  logic     wsm_susp,
    output rd_mode_t mode_q,
    output logic     cmd_stb,
    output logic     clr_stb,
    output logic     cap_stb
);
    logic we_d;
    logic idle_d;
    logic idle_now;
    logic array_ok;
    rd_mode_t mode_nxt;

    assign idle_now = ce_s & oe_s;
    assign cmd_stb  = we_s & ~we_d & ~ce_s;
    assign cap_stb  = idle_d & ~idle_now;
    assign clr_stb  = cmd_stb & (cmd_byte == CMD_CLEAR);
    assign array_ok = ~wsm_busy | wsm_susp;

    // Delay the strobes by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_d   <= 1'b1;
            idle_d <= 1'b1;
        end else begin
            we_d   <= we_s;
            idle_d <= idle_now;
        end
    end

    // Pick the next read mode from a decoded command byte.
    always_comb begin
        mode_nxt = mode_q;
        if (cmd_stb) begin
            unique case (cmd_byte)
                CMD_ARRAY:  if (array_ok) mode_nxt = RM_ARRAY;
                CMD_IDENT:  mode_nxt = RM_IDENT;
                CMD_STATUS: mode_nxt = RM_STATUS;
                default:    mode_nxt = mode_q;
            endcase
        end
    end

    // Hold the read mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= RM_ARRAY;
        else        mode_q <= mode_nxt;
    end
endmodule

// File: rtl/nor_status_reg.sv
// nor_status_reg: sticky error flags and the status byte latch.
// Assumes err_set pulses are synchronous to clk; a set beats a clear.
module nor_status_reg #(
    parameter int N_ERR = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ERR-1:0] err_set,
    input  logic             clr_stb,
    input  logic             cap_stb,
    input  logic             wsm_busy,
    input  logic             wsm_susp,
    output logic [N_ERR-1:0] err_q,
    output logic [7:0]       sr_latch
);
    logic [7:0] sr_live;

    // Sticky flags: clear first, then OR in new pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (err_q & {N_ERR{~clr_stb}}) | err_set;
    end

    // Assemble the live status byte from the flags and machine levels.
    always_comb begin
        sr_live    = 8'h00;
        sr_live[7] = ~wsm_busy;
        sr_live[6] = wsm_susp;
        sr_live[5] = err_q[3];
        sr_live[4] = err_q[2];
        sr_live[3] = err_q[1];
        sr_live[1] = err_q[0];
    end

    // Freeze the status byte when a read access begins.
    always_ff @(posedge clk) begin
        if (!rst_n)       sr_latch <= 8'h00;
        else if (cap_stb) sr_latch <= sr_live;
    end
endmodule

// File: rtl/nor_read_mux.sv
// nor_read_mux: steers the read bus between array, identifier, lock and
// status sources and applies the byte-wide bus rules.
// Assumes addr is a word address; addr_lsb matters only in byte mode.
module nor_read_mux
    import nor_rd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BLK_W  = 4,
    localparam int NBLK  = 2 ** (ADDR_W - BLK_W)
) (
    input  rd_mode_t          mode_q,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_lsb,
    input  logic              byte_mode,
    input  logic [DQ_W-1:0]   arr_data,
    input  logic [NBLK-1:0]   lock_bits,
    input  logic [7:0]        sr_latch,
    output logic [DQ_W-1:0]   dq_out
);
    logic [7:0]            id_byte;
    logic [DQ_W-1:0]       arr_word;
    logic [BLK_W-1:0]      blk_ofs;
    logic [ADDR_W-BLK_W-1:0] blk_idx;

    assign blk_ofs = addr[BLK_W-1:0];
    assign blk_idx = addr[ADDR_W-1:BLK_W];

    // Identifier space decode; addr_lsb is not consulted here.
    always_comb begin
        id_byte = 8'h00;
        if (addr == ADDR_W'(0))
            id_byte = ID_MFR;
        else if (addr == ADDR_W'(1))
            id_byte = ID_DEV;
        else if (blk_ofs == BLK_W'(LOCK_OFS))
            id_byte = {7'b0, lock_bits[blk_idx]};
    end

    // Array word or selected byte, depending on bus width.
    always_comb begin
        if (byte_mode)
            arr_word = {8'h00, (addr_lsb ? arr_data[15:8] : arr_data[7:0])};
        else
            arr_word = arr_data;
    end

    // Final source select.
    always_comb begin
        unique case (mode_q)
            RM_IDENT:  dq_out = {8'h00, id_byte};
            RM_STATUS: dq_out = {8'h00, sr_latch};
            default:   dq_out = arr_word;
        endcase
    end
endmodule

// File: rtl/nor_cmd_readmux.sv
// nor_cmd_readmux: command interface and read-path steering of an
// asynchronous parallel NOR flash. Strobes are synchronized to clk;
// the write state machine interface is synchronous to clk.
module nor_cmd_readmux
    import nor_rd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BLK_W  = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ce_n,
    input  logic                            oe_n,
    input  logic                            we_n,
    input  logic [ADDR_W-1:0]               addr,
    input  logic                            addr_lsb,
    input  logic                            byte_mode,
    input  logic [7:0]                      dq_in,
    input  logic                            wsm_busy,
    input  logic                            wsm_susp,
    input  logic [3:0]                      err_set,
    input  logic [2**(ADDR_W-BLK_W)-1:0]    lock_bits,
    input  logic [15:0]                     arr_data,
    output logic [15:0]                     dq_out
);
    logic [2:0] strb_s;
    rd_mode_t   mode_q;
    logic       cmd_stb;
    logic       clr_stb;
    logic       cap_stb;
    logic [3:0] err_q;
    logic [7:0] sr_latch;

    nor_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({we_n, oe_n, ce_n}),
        .q       (strb_s)
    );

    nor_cmd_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_s     (strb_s[0]),
        .oe_s     (strb_s[1]),
        .we_s     (strb_s[2]),
        .cmd_byte (dq_in),
        .wsm_busy (wsm_busy),
        .wsm_susp (wsm_susp),
        .mode_q   (mode_q),
        .cmd_stb  (cmd_stb),
        .clr_stb  (clr_stb),
        .cap_stb  (cap_stb)
    );

    nor_status_reg #(.N_ERR(4)) u_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_set  (err_set),
        .clr_stb  (clr_stb),
        .cap_stb  (cap_stb),
        .wsm_busy (wsm_busy),
        .wsm_susp (wsm_susp),
        .err_q    (err_q),
        .sr_latch (sr_latch)
    );

    nor_read_mux #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_mux (
        .mode_q    (mode_q),
        .addr      (addr),
        .addr_lsb  (addr_lsb),
        .byte_mode (byte_mode),
        .arr_data  (arr_data),
        .lock_bits (lock_bits),
        .sr_latch  (sr_latch),
        .dq_out    (dq_out)
    );
endmodule

// File: rtl/nor_cmd_readmux_chk.sv
// nor_cmd_readmux_chk: temporal checks on mode, flags and status latch,
// bound into every instance of the top module.
module nor_cmd_readmux_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_q,
    input logic       cmd_stb,
    input logic [7:0] cmd_byte,
    input logic       wsm_busy,
    input logic       wsm_susp,
    input logic       clr_stb,
    input logic       cap_stb,
    input logic [3:0] err_set,
    input logic [3:0] err_q,
    input logic [7:0] sr_latch
);
    // R1: reset leaves array mode and no flags.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (mode_q == 2'd0 && err_q == 4'd0));

    // R8: refused array command keeps the mode.
    a_r8_busy_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_byte == 8'hFF && wsm_busy && !wsm_susp) |=> $stable(mode_q));

    // R9: no command, no mode change.
    a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_stb |=> $stable(mode_q));

    // R6: without a clear, no flag ever falls.
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_stb |=> ((err_q & $past(err_q)) == $past(err_q)));

    // R10: a pulsed flag is set in the next cycle, clear or not.
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (err_set != 4'd0) |=> ((err_q & $past(err_set)) == $past(err_set)));

    // R7: latch only moves on a capture event.
    a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_stb |=> $stable(sr_latch));
endmodule

bind nor_cmd_readmux nor_cmd_readmux_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_q   (mode_q),
    .cmd_stb  (cmd_stb),
    .cmd_byte (dq_in),
    .wsm_busy (wsm_busy),
    .wsm_susp (wsm_susp),
    .clr_stb  (clr_stb),
    .cap_stb  (cap_stb),
    .err_set  (err_set),
    .err_q    (err_q),
    .sr_latch (sr_latch)
);

// File: tb/nor_cmd_readmux_bench.sv
// Self-checking bench: sweeps the whole address space in each read mode
// and walks the status, clear and refusal corner cases.
module nor_cmd_readmux_bench;
    localparam int ADDR_W = 8;
    localparam int BLK_W  = 4;
    localparam int NBLK   = 2 ** (ADDR_W - BLK_W);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              addr_lsb = 1'b0;
    logic              byte_mode = 1'b0;
    logic [7:0]        dq_in = 8'h00;
    logic              wsm_busy = 1'b0, wsm_susp = 1'b0;
    logic [3:0]        err_set = 4'h0;
    logic [NBLK-1:0]   lock_bits = '0;
    logic [15:0]       arr_data;
    logic [15:0]       dq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    assign arr_data = {addr, ~addr};

    always #2.5 clk = ~clk;

    nor_cmd_readmux #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_nor_cmd_readmux (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .addr_lsb(addr_lsb), .byte_mode(byte_mode), .dq_in(dq_in),
        .wsm_busy(wsm_busy), .wsm_susp(wsm_susp), .err_set(err_set),
        .lock_bits(lock_bits), .arr_data(arr_data), .dq_out(dq_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%04h expected=%04h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cmd(input logic [7:0] code, input logic ce_lvl);
        @(negedge clk);
        ce_n = ce_lvl; dq_in = code; we_n = 1'b0;
        wait_n(4);
        we_n = 1'b1;
        wait_n(5);
        ce_n = 1'b1;
        wait_n(4);
    endtask

    // Both strobes high, then a new access begins.
    task automatic open_read();
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        wait_n(4);
        ce_n = 1'b0; oe_n = 1'b0;
        wait_n(5);
    endtask

    task automatic pulse_err(input logic [3:0] v);
        @(negedge clk); err_set = v;
        @(negedge clk); err_set = 4'h0;
    endtask

    function automatic logic [15:0] exp_id(input logic [ADDR_W-1:0] a, input logic [NBLK-1:0] lk);
        if (a == 0) return 16'h00B0;
        if (a == 1) return 16'h00E9;
        if (a[BLK_W-1:0] == 2) return {15'b0, lk[a[ADDR_W-1:BLK_W]]};
        return 16'h0000;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        wait_n(6);
        rst_n = 1'b1;
        wait_n(3);

        // R1: array mode after reset
        addr = 8'h5A; #1;
        chk("R1 reset array", dq_out, {8'h5A, 8'hA5});

        // R4: array sweep in both widths
        for (int a = 0; a < 2 ** ADDR_W; a++) begin
            addr = ADDR_W'(a);
            byte_mode = 1'b0; addr_lsb = 1'b0; #1;
            chk("R1 array word", dq_out, {addr, ~addr});
            byte_mode = 1'b1; #1;
            chk("R4 array low byte", dq_out, {8'h00, ~addr});
            addr_lsb = 1'b1; #1;
            chk("R4 array high byte", dq_out, {8'h00, addr});
        end
        byte_mode = 1'b0; addr_lsb = 1'b0;

        // R2: write with chip disabled is ignored
        write_cmd(8'h90, 1'b1);
        addr = 8'h00; #1;
        chk("R2 we with ce high", dq_out, {8'h00, 8'hFF});

        // R3/R4: identifier sweep, two lock patterns
        write_cmd(8'h90, 1'b0);
        for (int p = 0; p < 2; p++) begin
            lock_bits = (p == 0) ? 16'hA5C3 : 16'h5A3C;
            for (int a = 0; a < 2 ** ADDR_W; a++) begin
                addr = ADDR_W'(a);
                for (int bm = 0; bm < 2; bm++) begin
                    for (int l = 0; l < 2; l++) begin
                        byte_mode = bm[0]; addr_lsb = l[0]; #1;
                        chk("R3 R4 ident", dq_out, exp_id(addr, lock_bits));
                    end
                end
            end
        end
        byte_mode = 1'b0; addr_lsb = 1'b0;

        // R9: unknown code keeps identifier mode
        write_cmd(8'h12, 1'b0);
        addr = 8'h01; #1;
        chk("R9 unknown code", dq_out, 16'h00E9);

        // R5: status mode, ready with no flags
        write_cmd(8'h70, 1'b0);
        open_read();
        chk("R5 status idle", dq_out, 16'h0080);

        // R6: flags accumulate
        pulse_err(4'b1010);
        open_read();
        chk("R6 first flags", dq_out, 16'h00A8);
        pulse_err(4'b0001);
        open_read();
        chk("R6 accumulate", dq_out, 16'h00AA);

        // R6: clear keeps status mode
        write_cmd(8'h50, 1'b0);
        open_read();
        chk("R6 clear", dq_out, 16'h0080);

        // R7: latch holds under an open access
        @(negedge clk); wsm_busy = 1'b1;
        wait_n(5);
        chk("R7 hold while open", dq_out, 16'h0080);
        oe_n = 1'b1; wait_n(4); oe_n = 1'b0; wait_n(5);
        chk("R7 oe only retoggle", dq_out, 16'h0080);
        open_read();
        chk("R7 refresh busy", dq_out, 16'h0000);

        // R8: array command refused while busy
        addr = 8'h33;
        write_cmd(8'hFF, 1'b0);
        open_read();
        chk("R8 refused busy", dq_out, 16'h0000);
        @(negedge clk); wsm_susp = 1'b1;
        open_read();
        chk("R5 suspended bit", dq_out, 16'h0040);
        write_cmd(8'hFF, 1'b0);
        #1;
        chk("R8 accepted suspended", dq_out, {8'h33, 8'hCC});
        @(negedge clk); wsm_busy = 1'b0; wsm_susp = 1'b0;

        // R10: set and clear in the same cycle
        write_cmd(8'h70, 1'b0);
        pulse_err(4'b1000);
        @(negedge clk);
        ce_n = 1'b0; dq_in = 8'h50; we_n = 1'b0;
        wait_n(4);
        we_n = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); err_set = 4'b0100;
        @(posedge clk);
        @(negedge clk); err_set = 4'h0;
        wait_n(4);
        ce_n = 1'b1;
        open_read();
        chk("R10 set beats clear", dq_out, 16'h0090);

        // R8: idle array command accepted
        write_cmd(8'hFF, 1'b0);
        addr = 8'h0F; #1;
        chk("R8 accepted idle", dq_out, {8'h0F, 8'hF0});

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule